// File: doc/BRIEF.md
# Boot Mode and Program Map Controller

This block fixes the chip's operating mode while reset is held and then selects which program-space memory map is used. Two mode bits are captured on each clock edge that sees reset high. The security bit comes from a flash status input, where 1 means the flash is unsecured. The map-select bit comes from an external-boot pin. The value captured on the last such edge is the one that holds. An illegal pairing, secured flash with an external-boot request, is resolved to the secured internal state. From the resolved mode the block derives registered outputs: boot source, the address-line count of the external memory interface, debug enable, and permission to use external program space.

After reset, software sees a two-bit register. It reads both effective bits and may rewrite only the map-select bit. Such a write takes effect only when the flash was unsecured at reset. The security bit and all boot-time outputs stay frozen until the next reset, whatever happens on the pins or on the register port.

Top module: `boot_map_ctrl`

## Requirements
- R1: On every clock edge with `rst` high, the security bit (readback bit 1) is loaded from `flash_unsecured_i`, where 1 means unsecured and 0 means secured.
- R2: On every clock edge with `rst` high, the map-select bit (readback bit 0) is loaded from `ext_boot_i`. When the security bit is captured as 0, the map-select bit is forced to 0, so the invalid pairing 0/1 becomes 0/0.
- R3: In the resolved state security 0 / map 0, the block reports internal boot (`boot_external_o`=0) and `emi_lines_o`=16. It also drives `ext_pspace_ok_o`=0 and `debug_en_o`=0.
- R4: In the resolved state security 1 / map 0, the block reports internal boot and `emi_lines_o`=16. It also drives `ext_pspace_ok_o`=1 and `debug_en_o`=1.
- R5: In the resolved state security 1 / map 1, the block reports external boot (`boot_external_o`=1) with `ext_pspace_ok_o`=1 and `debug_en_o`=1. `emi_lines_o` is 24 if `emi_wide_i` was high at the same reset edge, and 16 otherwise.
- R6: While `rst` is low, changes on `flash_unsecured_i`, `ext_boot_i` or `emi_wide_i` change no output and no readback bit.
- R7: A write to bit 1 of the register has no effect: the readback security bit, the map-select bit and all boot-time outputs keep their values.
- R8: With security bit 1, a cycle with `reg_wr_i` high loads `reg_wdata_i[0]` into the map-select bit, visible on `pmap_external_o` and readback bit 0 after that clock edge (0 = internal map, 1 = external map). Without a write, the bit holds.
- R9: With security bit 0, writes leave the map-select bit at 0.
- R10: `reg_rdata_o` is `{security bit, map-select bit}` in the same cycle, and `reg_rdata_o[0]` always equals `pmap_external_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; mode pins are captured while high |
| flash_unsecured_i | input | 1 | Flash security status, 1 = unsecured |
| ext_boot_i | input | 1 | External-boot request pin |
| emi_wide_i | input | 1 | Requests the wide external-interface address configuration |
| reg_wr_i | input | 1 | Single-cycle register write strobe |
| reg_wdata_i | input | 2 | Write data: bit 0 map select, bit 1 security (ignored) |
| reg_rdata_o | output | 2 | Readback {security, map select} |
| boot_external_o | output | 1 | 1 = external boot selected |
| emi_lines_o | output | 5 | Number of external-interface address lines |
| debug_en_o | output | 1 | Debug unit enable |
| ext_pspace_ok_o | output | 1 | External program space permitted |
| pmap_external_o | output | 1 | 1 = external program-space map in use |

## Verification
A wrong captured security bit shows at the ports as soon as reset drops: `debug_en_o`, `ext_pspace_ok_o` and readback bit 1 disagree together. A leaky capture path shows only after a pin toggles outside reset, on the edge after the toggle. A broken write gate shows on `pmap_external_o` one edge after the strobe. That covers both a locked state that accepts a write and an unsecured state that refuses one. All eight pin combinations are walked through reset, and then the post-reset pin changes and write attempts are applied in each relevant state.

// File: rtl/bmc_pkg.sv
package bmc_pkg;
  localparam int REG_W   = 2;
  localparam int MAP_BIT = 0;
  localparam int SEC_BIT = 1;

  // Resolved mode after illegal-combination handling
  typedef struct packed {
    logic sec;       // 1 = flash unsecured
    logic map;       // 1 = external boot / external map
    logic wide_req;  // wide interface requested in external boot
  } mode_t;

  // Boot-time configuration held until next reset
  typedef struct packed {
    logic boot_ext;
    logic wide;
    logic dbg_en;
    logic pspace_ok;
    logic sec;
    logic map;
  } cfg_t;
endpackage

// File: rtl/bmc_resolve.sv
module bmc_resolve
  import bmc_pkg::*;
(
  input  logic  flash_unsecured,
  input  logic  ext_boot,
  input  logic  emi_wide,
  output mode_t mode
);
  always_comb begin
    mode.sec      = flash_unsecured;
    // secured flash cannot boot externally: fold 0/1 into 0/0
    mode.map      = flash_unsecured & ext_boot;
    mode.wide_req = flash_unsecured & ext_boot & emi_wide;
  end
endmodule

// File: rtl/bmc_decode.sv
module bmc_decode
  import bmc_pkg::*;
(
  input  mode_t mode,
  output cfg_t  cfg
);
  always_comb begin
    cfg.sec       = mode.sec;
    cfg.map       = mode.map;
    cfg.boot_ext  = mode.map;
    cfg.wide      = mode.map & mode.wide_req;
    // only the secured internal state turns debug off and bars external P-space
    cfg.dbg_en    = mode.sec;
    cfg.pspace_ok = mode.sec;
  end
endmodule

// File: rtl/bmc_latch.sv
module bmc_latch
  import bmc_pkg::*;
#(
  parameter int NARROW_LINES = 16,
  parameter int WIDE_LINES   = 24,
  parameter int LINE_W       = $clog2(WIDE_LINES + 1)
)(
  input  logic              clk,
  input  logic              rst,
  input  cfg_t              cfg_in,
  output cfg_t              cfg_q,
  output logic [LINE_W-1:0] lines_q
);
  localparam logic [LINE_W-1:0] NARROW_V = LINE_W'(NARROW_LINES);
  localparam logic [LINE_W-1:0] WIDE_V   = LINE_W'(WIDE_LINES);

  // capture continuously while reset is held; frozen afterwards
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q   <= cfg_in;
      lines_q <= cfg_in.wide ? WIDE_V : NARROW_V;
    end
  end
endmodule

// File: rtl/bmc_pmap.sv
module bmc_pmap (
  input  logic clk,
  input  logic rst,
  input  logic init_map,
  input  logic sec_q,
  input  logic wr,
  input  logic wdata_map,
  output logic map_q
);
  always_ff @(posedge clk) begin
    if (rst)
      map_q <= init_map;
    else if (wr && sec_q)
      map_q <= wdata_map;
  end
endmodule

// File: rtl/boot_map_ctrl.sv
module boot_map_ctrl
  import bmc_pkg::*;
#(
  parameter int NARROW_LINES = 16,
  parameter int WIDE_LINES   = 24,
  parameter int LINE_W       = $clog2(WIDE_LINES + 1)
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              flash_unsecured_i,
  input  logic              ext_boot_i,
  input  logic              emi_wide_i,
  input  logic              reg_wr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              boot_external_o,
  output logic [LINE_W-1:0] emi_lines_o,
  output logic              debug_en_o,
  output logic              ext_pspace_ok_o,
  output logic              pmap_external_o
);
  mode_t mode_live;
  cfg_t  cfg_live;
  cfg_t  cfg_q;
  logic  map_q;
  logic  unused_sec_wr;

  // security field of a write is accepted on the bus but discarded
  assign unused_sec_wr = reg_wdata_i[SEC_BIT];

  bmc_resolve u_resolve (
    .flash_unsecured (flash_unsecured_i),
    .ext_boot        (ext_boot_i),
    .emi_wide        (emi_wide_i),
    .mode            (mode_live)
  );

  bmc_decode u_decode (
    .mode (mode_live),
    .cfg  (cfg_live)
  );

  bmc_latch #(
    .NARROW_LINES (NARROW_LINES),
    .WIDE_LINES   (WIDE_LINES),
    .LINE_W       (LINE_W)
  ) u_latch (
    .clk     (clk),
    .rst     (rst),
    .cfg_in  (cfg_live),
    .cfg_q   (cfg_q),
    .lines_q (emi_lines_o)
  );

  bmc_pmap u_pmap (
    .clk       (clk),
    .rst       (rst),
    .init_map  (cfg_live.map),
    .sec_q     (cfg_q.sec),
    .wr        (reg_wr_i),
    .wdata_map (reg_wdata_i[MAP_BIT]),
    .map_q     (map_q)
  );

  always_comb begin
    reg_rdata_o          = '0;
    reg_rdata_o[SEC_BIT] = cfg_q.sec;
    reg_rdata_o[MAP_BIT] = map_q;
  end

  assign boot_external_o = cfg_q.boot_ext;
  assign debug_en_o      = cfg_q.dbg_en;
  assign ext_pspace_ok_o = cfg_q.pspace_ok;
  assign pmap_external_o = map_q;
endmodule

// File: rtl/bmc_checker.sv
module bmc_checker
  import bmc_pkg::*;
#(
  parameter int NARROW_LINES = 16,
  parameter int LINE_W       = 5
)(
  input logic              clk,
  input logic              rst,
  input logic              reg_wr_i,
  input logic [REG_W-1:0]  reg_wdata_i,
  input logic [REG_W-1:0]  reg_rdata_o,
  input logic              boot_external_o,
  input logic [LINE_W-1:0] emi_lines_o,
  input logic              debug_en_o,
  input logic              ext_pspace_ok_o,
  input logic              pmap_external_o
);
  AST_SECURE_LOCKDOWN: assert property (@(posedge clk) disable iff (rst)
    !reg_rdata_o[SEC_BIT] |-> (!debug_en_o && !ext_pspace_ok_o && !boot_external_o)); // R3
  AST_INTERNAL_NARROW: assert property (@(posedge clk) disable iff (rst)
    !boot_external_o |-> (emi_lines_o == LINE_W'(NARROW_LINES))); // R4
  AST_EXTBOOT_PERMITTED: assert property (@(posedge clk) disable iff (rst)
    boot_external_o |-> (ext_pspace_ok_o && debug_en_o)); // R5
  AST_FROZEN_CONFIG: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ($stable(boot_external_o) && $stable(emi_lines_o) &&
                     $stable(debug_en_o) && $stable(reg_rdata_o[SEC_BIT]))); // R6
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_i && reg_rdata_o[SEC_BIT]) |=> (pmap_external_o == $past(reg_wdata_i[MAP_BIT]))); // R8
  AST_MAP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !reg_wr_i |=> $stable(pmap_external_o)); // R8
  AST_LOCKED_MAP: assert property (@(posedge clk) disable iff (rst)
    !reg_rdata_o[SEC_BIT] |-> !pmap_external_o); // R9
  AST_READBACK_MAP: assert property (@(posedge clk) disable iff (rst)
    reg_rdata_o[MAP_BIT] == pmap_external_o); // R10
endmodule

bind boot_map_ctrl bmc_checker #(
  .NARROW_LINES (NARROW_LINES),
  .LINE_W       (LINE_W)
) u_chk (
  .clk             (clk),
  .rst             (rst),
  .reg_wr_i        (reg_wr_i),
  .reg_wdata_i     (reg_wdata_i),
  .reg_rdata_o     (reg_rdata_o),
  .boot_external_o (boot_external_o),
  .emi_lines_o     (emi_lines_o),
  .debug_en_o      (debug_en_o),
  .ext_pspace_ok_o (ext_pspace_ok_o),
  .pmap_external_o (pmap_external_o)
);

// File: tb/boot_map_ctrl_test.sv
module boot_map_ctrl_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fu = 1'b0, eb = 1'b0, ew = 1'b0;
  logic       wr = 1'b0;
  logic [1:0] wdata = 2'b00;
  logic [1:0] rdata;
  logic       bext, dbg, pok, pmap;
  logic [4:0] lines;
  int         n_chk = 0, n_fail = 0;
  bit         done = 0;

  always #5 clk = ~clk;

  boot_map_ctrl uut (
    .clk (clk), .rst (rst),
    .flash_unsecured_i (fu), .ext_boot_i (eb), .emi_wide_i (ew),
    .reg_wr_i (wr), .reg_wdata_i (wdata), .reg_rdata_o (rdata),
    .boot_external_o (bext), .emi_lines_o (lines), .debug_en_o (dbg),
    .ext_pspace_ok_o (pok), .pmap_external_o (pmap)
  );

  // {fu, eb, ew, boot_ext, wide, dbg, pspace_ok, map}
  localparam logic [7:0] VEC [8] = '{
    8'b000_00000, 8'b001_00000, 8'b010_00000, 8'b011_00000,
    8'b100_00110, 8'b101_00110, 8'b110_10111, 8'b111_11111
  };

  task automatic check(string req, string what, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic do_reset(logic f, logic e, logic w);
    @(negedge clk);
    rst = 1'b1; fu = f; eb = e; ew = w;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
  endtask

  task automatic do_write(logic [1:0] d);
    @(negedge clk);
    wr = 1'b1; wdata = d;
    @(negedge clk);
    wr = 1'b0; wdata = 2'b00;
    #1;
  endtask

  task automatic check_cfg(string req, logic be, logic [4:0] ln, logic de, logic ok, logic [1:0] rb);
    check(req, "boot_external", 8'(bext), 8'(be));
    check(req, "emi_lines", 8'(lines), 8'(ln));
    check(req, "debug_en", 8'(dbg), 8'(de));
    check(req, "pspace_ok", 8'(pok), 8'(ok));
    check(req, "readback", 8'(rdata), 8'(rb));
    check("R10", "pmap_vs_readback", 8'(pmap), 8'(rb[0]));
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    // table walk: R1 R2 R3 R4 R5 across every pin combination
    for (int i = 0; i < 8; i++) begin
      logic [7:0] v;
      v = VEC[i];
      do_reset(v[7], v[6], v[5]);
      check_cfg(v[4] ? "R5" : (v[1] ? "R4" : "R3"),
                v[4], v[3] ? 5'd24 : 5'd16, v[2], v[1], {v[7], v[0]});
      check("R2", "map_forced", 8'(pmap), 8'(v[7] & v[6]));
    end

    // R6: pins toggle after reset in the unsecured internal state
    do_reset(1'b1, 1'b0, 1'b0);
    @(negedge clk); fu = 1'b0; eb = 1'b1; ew = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check_cfg("R6", 1'b0, 5'd16, 1'b1, 1'b1, 2'b10);

    // R6: pins toggle after reset in the secured state
    do_reset(1'b0, 1'b0, 1'b0);
    @(negedge clk); fu = 1'b1; eb = 1'b1; ew = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check_cfg("R6", 1'b0, 5'd16, 1'b0, 1'b0, 2'b00);

    // R9: writes in secured state keep map at 0; R7 security bit unchanged
    do_write(2'b11);
    check_cfg("R9", 1'b0, 5'd16, 1'b0, 1'b0, 2'b00);
    do_write(2'b01);
    check("R9", "pmap_locked", 8'(pmap), 8'd0);

    // R8: unsecured internal state, switch maps
    do_reset(1'b1, 1'b0, 1'b0);
    @(negedge clk); wr = 1'b1; wdata = 2'b11;
    #1;
    check("R8", "map_before_edge", 8'(pmap), 8'd0);
    @(negedge clk); wr = 1'b0; wdata = 2'b00;
    #1;
    check("R8", "map_after_write1", 8'(pmap), 8'd1);
    check("R10", "readback_after_write1", 8'(rdata), 8'b11);
    repeat (3) @(negedge clk);
    #1;
    check("R8", "map_holds", 8'(pmap), 8'd1);
    do_write(2'b00);
    check("R8", "map_after_write0", 8'(pmap), 8'd0);

    // R7: write clearing the security bit while external boot
    do_reset(1'b1, 1'b1, 1'b1);
    do_write(2'b01);
    check_cfg("R7", 1'b1, 5'd24, 1'b1, 1'b1, 2'b11);
    do_write(2'b00);
    check_cfg("R7", 1'b1, 5'd24, 1'b1, 1'b1, 2'b10);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule